// File: doc/BRIEF.md
# Flash Write-Command Sequence Decoder

This block sits between the host-facing write path of a byte-wide parallel flash and its array controller. The host writes address/data pairs. A command is accepted only after a fixed two-write unlock prefix. The decoder follows the sequence write by write and, when a sequence completes, it raises a one-cycle request to the controller. Three requests exist: program one byte, erase the whole chip, and lock the boot region.

The decoder also keeps an identification flag. While the flag is set, the read port returns identification bytes in place of array data. The flag is set and cleared by commands, and a reset clears it. A write counts as accepted when `wr_en` is high and `busy` is low at a rising clock edge. Requests and the flag change at that same edge, so they are visible in the following cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock prefix is data 0xAA at address 0x5555, then data 0x55 at address 0x2AAA. Only address bits 14..0 are compared; higher address bits have no effect on matching.
- R2: After the prefix, a third write of 0xA0 at 0x5555 arms a byte program. The next accepted write, at any address, produces `prog_req` high for exactly one cycle, with `prog_addr`/`prog_data` equal to that write's address and data.
- R3: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 produce `erase_req` high for exactly one cycle.
- R4: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 40@5555 produce `lock_req` high for exactly one cycle.
- R5: After the prefix, a third write of 0x90 at 0x5555 sets `id_mode`.
- R6: `id_mode` is cleared by a write of 0xF0 to any address when no sequence is in progress. It is also cleared by the prefix followed by 0xF0 at 0x5555.
- R7: While `id_mode` is high, `rd_data` is driven as follows. Read address 0 gives the manufacturer code 0x1F. Address 1 gives the device code: 0x23 with TOP_BOOT=0, or 0x27 with TOP_BOOT=1. Address 2 gives `{7'b0, boot_locked}`. Any other address gives 0x00. While `id_mode` is low, `rd_data` equals `array_rdata`.
- R8: An accepted write that does not match the expected next write returns the decoder to idle and issues no request. A following full sequence is then decoded normally.
- R9: Writes presented while `busy` is high are ignored: they neither advance nor break a sequence in progress, and they issue no request.
- R10: Reset clears `id_mode`, abandons any partial sequence and holds all requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Controller busy; writes are ignored while high |
| boot_locked | input | 1 | Boot region lock status from the controller |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | 8 | Array read data from the controller |
| rd_data | output | 8 | Read data: array data or an identification byte |
| id_mode | output | 1 | Identification mode active |
| prog_req | output | 1 | One-cycle byte program request |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data |
| erase_req | output | 1 | One-cycle chip erase request |
| lock_req | output | 1 | One-cycle boot lockout request |

## Verification
The hardest case to reach is a write that arrives while `busy` is high in the middle of an unlock or command sequence. The decoder must ignore that write completely, so the sequence neither advances nor falls back to idle.

The bench reaches this case by pausing a sequence after its first write, raising `busy`, and presenting a write that would otherwise break the sequence. It then finishes the sequence and expects a normal program request. A second scenario raises `busy` only for the armed fourth write and expects no request until a later write is accepted. Upper address bits are also driven to non-zero values to confirm that matching uses only the low fifteen bits.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 20,
  parameter bit TOP_BOOT = 1'b0,
  parameter logic [7:0] MFR_CODE = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              boot_locked,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rdata,
  output logic [7:0]        rd_data,
  output logic              id_mode,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_req,
  output logic              lock_req
);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? 8'h27 : 8'h23;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PRG, S_E1, S_E2, S_E3} st_t;
  st_t st, st_nx;

  wire acc   = wr_en && !busy;
  wire at_lo = wr_addr[14:0] == 15'h5555;
  wire at_hi = wr_addr[14:0] == 15'h2AAA;

  always_comb begin
    st_nx = S_IDLE;
    case (st)
      S_IDLE: if (at_lo && wr_data == 8'hAA) st_nx = S_U1;
      S_U1:   if (at_hi && wr_data == 8'h55) st_nx = S_U2;
      S_U2:   if (at_lo && wr_data == 8'hA0) st_nx = S_PRG;
              else if (at_lo && wr_data == 8'h80) st_nx = S_E1;
      S_E1:   if (at_lo && wr_data == 8'hAA) st_nx = S_E2;
      S_E2:   if (at_hi && wr_data == 8'h55) st_nx = S_E3;
      default: st_nx = S_IDLE;
    endcase
  end

  wire fire_prog  = acc && st == S_PRG;
  wire fire_erase = acc && st == S_E3 && at_lo && wr_data == 8'h10;
  wire fire_lock  = acc && st == S_E3 && at_lo && wr_data == 8'h40;
  wire id_set     = acc && st == S_U2 && at_lo && wr_data == 8'h90;
  wire id_clr     = acc && wr_data == 8'hF0 && (st == S_IDLE || (st == S_U2 && at_lo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      id_mode   <= 1'b0;
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      lock_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      if (acc) st <= st_nx;
      if (id_set) id_mode <= 1'b1;
      else if (id_clr) id_mode <= 1'b0;
      prog_req  <= fire_prog;
      erase_req <= fire_erase;
      lock_req  <= fire_lock;
      if (fire_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  always_comb begin
    if (!id_mode)                                rd_data = array_rdata;
    else if (rd_addr == ADDR_W'(0))              rd_data = MFR_CODE;
    else if (rd_addr == ADDR_W'(1))              rd_data = DEV_CODE;
    else if (rd_addr == ADDR_W'(2))              rd_data = {7'b0, boot_locked};
    else                                         rd_data = 8'h00;
  end

  assert_one_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req, lock_req}));
  assert_erase_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) || !erase_req || ($past(wr_data) == 8'h10 && $past(wr_addr[14:0]) == 15'h5555 && $past(wr_en)));
  assert_lock_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) || !lock_req || ($past(wr_data) == 8'h40 && $past(wr_en)));
  assert_id_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(acc && wr_data == 8'h90));
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || !wr_en) |=> !prog_req && !erase_req && !lock_req);
  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int AW = 20;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, busy = 1'b0, boot_locked = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, prog_addr;
  logic [7:0] wr_data = '0, array_rdata = 8'hC3, rd_data, prog_data;
  logic id_mode, prog_req, erase_req, lock_req;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .TOP_BOOT(1'b0)) dut_i (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .busy, .boot_locked, .rd_addr,
    .array_rdata, .rd_data, .id_mode, .prog_req, .prog_addr, .prog_data,
    .erase_req, .lock_req);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
  endtask

  task automatic reqs_none(input string tag);
    chk({prog_req, erase_req, lock_req} == 3'b000, tag, {prog_req, erase_req, lock_req}, 0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a; #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(id_mode == 1'b0, "R10 id_mode after reset", id_mode, 0);
    reqs_none("R10 requests after reset");
    rd(20'h0, 8'hC3, "R10 array data after reset");
  endtask

  task automatic t_program();
    unlock(); wr(20'h05555, 8'hA0);
    reqs_none("R2 no request while arming");
    wr(20'h12345, 8'h5A);
    chk(prog_req == 1'b1, "R2 prog_req", prog_req, 1);
    chk(prog_addr == 20'h12345, "R2 prog_addr", prog_addr, 20'h12345);
    chk(prog_data == 8'h5A, "R2 prog_data", prog_data, 8'h5A);
    @(negedge clk);
    chk(prog_req == 1'b0, "R2 single-cycle pulse", prog_req, 0);
  endtask

  task automatic t_high_bits();
    wr(20'hF5555, 8'hAA); wr(20'hAAAAA, 8'h55); wr(20'h35555, 8'hA0);
    wr(20'h00077, 8'h11);
    chk(prog_req == 1'b1 && prog_data == 8'h11, "R1 upper bits ignored", prog_req, 1);
    wr(20'h05554, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0); wr(20'h00001, 8'h22);
    reqs_none("R1 wrong low address rejected");
  endtask

  task automatic t_erase_lock();
    unlock(); wr(20'h05555, 8'h80); unlock();
    reqs_none("R3 no early request");
    wr(20'h05555, 8'h10);
    chk(erase_req == 1'b1 && !lock_req && !prog_req, "R3 erase_req", erase_req, 1);
    @(negedge clk);
    chk(erase_req == 1'b0, "R3 single-cycle pulse", erase_req, 0);
    unlock(); wr(20'h05555, 8'h80); unlock(); wr(20'h05555, 8'h40);
    chk(lock_req == 1'b1 && !erase_req, "R4 lock_req", lock_req, 1);
    @(negedge clk);
    chk(lock_req == 1'b0, "R4 single-cycle pulse", lock_req, 0);
  endtask

  task automatic t_id();
    unlock(); wr(20'h05555, 8'h90);
    chk(id_mode == 1'b1, "R5 id_mode set", id_mode, 1);
    rd(20'h0, 8'h1F, "R7 manufacturer code");
    rd(20'h1, 8'h23, "R7 device code");
    boot_locked = 1'b0; rd(20'h2, 8'h00, "R7 lock status clear");
    boot_locked = 1'b1; rd(20'h2, 8'h01, "R7 lock status set");
    rd(20'h80000, 8'h00, "R7 other address");
    wr(20'h4321A, 8'hF0);
    chk(id_mode == 1'b0, "R6 single-write exit", id_mode, 0);
    rd(20'h0, 8'hC3, "R7 array data after exit");
    unlock(); wr(20'h05555, 8'h90);
    unlock(); wr(20'h05555, 8'hF0);
    chk(id_mode == 1'b0, "R6 three-write exit", id_mode, 0);
    unlock(); wr(20'h05555, 8'h90);
    wr(20'h05555, 8'hAA); wr(20'h00000, 8'hF0);
    chk(id_mode == 1'b1, "R6 F0 mid-sequence is no exit", id_mode, 1);
    wr(20'h0, 8'hF0);
  endtask

  task automatic t_mismatch();
    unlock(); wr(20'h05555, 8'h77);
    wr(20'h00100, 8'h33);
    reqs_none("R8 no request after mismatch");
    wr(20'h05555, 8'h55);
    reqs_none("R8 idle after stray write");
    unlock(); wr(20'h05555, 8'hA0); wr(20'h00200, 8'h44);
    chk(prog_req == 1'b1 && prog_addr == 20'h00200, "R8 recovery", prog_req, 1);
  endtask

  task automatic t_busy();
    wr(20'h05555, 8'hAA);
    busy = 1'b1; wr(20'h01111, 8'h99); busy = 1'b0;
    reqs_none("R9 busy write no request");
    wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0); wr(20'h00300, 8'h66);
    chk(prog_req == 1'b1 && prog_data == 8'h66, "R9 busy write did not break sequence", prog_req, 1);
    unlock(); wr(20'h05555, 8'hA0);
    busy = 1'b1; wr(20'h00400, 8'h12); busy = 1'b0;
    reqs_none("R9 armed write under busy");
    wr(20'h00500, 8'h34);
    chk(prog_req == 1'b1 && prog_addr == 20'h00500, "R9 armed state kept", prog_addr, 20'h00500);
  endtask

  task automatic t_reset_mid();
    unlock(); wr(20'h05555, 8'h90); unlock();
    do_reset();
    chk(id_mode == 1'b0, "R10 reset leaves id mode", id_mode, 0);
    wr(20'h05555, 8'hA0); wr(20'h00000, 8'h01);
    reqs_none("R10 partial sequence abandoned");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_program(); t_high_bits(); t_erase_lock();
        t_id(); t_mismatch(); t_busy(); t_reset_mid();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule